// File: doc/BRIEF.md
# Fault Register Capture Unit

This block collects error reports from the memory and I/O side of a processor into one 16-bit register of sticky flags. Three active-low error lines report memory protection, memory parity and external address problems. They are not watched continuously. The block registers them, along with the cycle-type indicators, on every clock. It acts on them only when the bus-busy qualifier drops, which marks the end of a bus cycle. Each value used is the one seen in the last busy cycle. The cycle type picks the target bit. A protection error goes to one of two bits depending on whether the CPU or another master ran the cycle. An address error goes to one of two bits depending on whether the access was to memory or to I/O.

Two system fault inputs are asynchronous to the clock. Each one passes through a synchroniser and a rising-edge detector, and then sets its own bits whether or not a bus cycle is in progress. A set bit stays set until a software clear strobe or a reset. Software reads the register through a read-enable gated data port. All pins are plain level control and status pins, and there is no flow-control handshake: a read returns data in the same cycle, and the clear strobe takes effect at the next clock edge.

Top module: `fault_reg_capture`

## Requirements
- R1: While reset is asserted, and right after it is released, the register holds 0x0000.
- R2: When prot_err_n is low in the last busy cycle and cyc_cpu is 1 in that cycle, bit 0 is set at the clock edge that ends the first non-busy cycle.
- R3: When prot_err_n is low in the last busy cycle and cyc_cpu is 0, bit 1 is set, with the same timing as R2.
- R4: When par_err_n is low in the last busy cycle, bit 2 is set, with the same timing as R2.
- R5: When addr_err_n is low in the last busy cycle, bit 5 is set if cyc_io is 0 (memory access) and bit 8 is set if cyc_io is 1 (I/O access).
- R6: Error levels have no effect unless bus_busy goes from 1 to 0. A low error line during busy cycles that rises again before the last busy cycle sets nothing, and neither does a low error line while bus_busy stays 0.
- R7: A rising edge on sys_fault[0] sets bit 7 on the third clock edge after it, and not before.
- R8: A rising edge on sys_fault[1] sets both bit 13 and bit 15, with the same latency as R7.
- R9: A system fault input held high sets its bits only once. After a clear, the bits stay 0 until the input falls and rises again.
- R10: Set bits stay set until clr_en is sampled high, and that clear zeroes every bit.
- R11: A bit that is set in the same cycle as a clear ends up 1 after that edge, while the other bits are cleared.
- R12: Bits 3, 4, 6, 9, 10, 11, 12 and 14 always read 0. With every source active, the register reads 0xA1A7.
- R13: rd_data shows the register while rd_en is 1 and reads 0x0000 while rd_en is 0. A read never changes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_busy | input | 1 | High while a bus cycle is running; its fall ends the cycle |
| cyc_cpu | input | 1 | 1 when the CPU owns the current cycle |
| cyc_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| prot_err_n | input | 1 | Active-low memory protection error |
| par_err_n | input | 1 | Active-low memory parity error |
| addr_err_n | input | 1 | Active-low external address error |
| sys_fault | input | 2 | Asynchronous system fault inputs, acting on rising edges |
| rd_en | input | 1 | Read strobe gating rd_data |
| clr_en | input | 1 | Clear strobe for all register bits |
| rd_data | output | 16 | Register value while rd_en is 1, zero otherwise |

## Verification
The bench builds the block with its default parameters: a 16-bit register, the default bit assignments and a two-stage synchroniser. The two-stage depth fixes the system-fault latency at three edges, so the bench can check both the cycle just before the bit appears and the cycle it does. Because the bit assignments are the defaults, every sourced bit and every unsourced bit can be reached. One set of bus cycles and fault edges can therefore drive the full 0xA1A7 pattern, and show that no other bit moves.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int FR_W = 16;

  // default bit assignments
  localparam int BIT_PROT_CPU  = 0;
  localparam int BIT_PROT_OTH  = 1;
  localparam int BIT_PARITY    = 2;
  localparam int BIT_ADDR_MEM  = 5;
  localparam int BIT_SYS0      = 7;
  localparam int BIT_ADDR_IO   = 8;
  localparam int BIT_SYS1_LO   = 13;
  localparam int BIT_SYS1_HI   = 15;

  localparam int NUM_SYS = 2;

  typedef logic [FR_W-1:0] fr_vec_t;

  function automatic fr_vec_t bit_at(input int pos);
    fr_vec_t v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fr_edge_sync.sv
module fr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  // STAGES synchroniser flops, then one flop for edge detection
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], async_i};
  end

  assign rise_o = shift_q[LAST] & ~shift_q[STAGES];

  // R7/R8: a detected edge is a single-cycle pulse
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fr_bus_sampler.sv
module fr_bus_sampler
  import fr_pkg::*;
#(
  parameter int POS_PROT_CPU = BIT_PROT_CPU,
  parameter int POS_PROT_OTH = BIT_PROT_OTH,
  parameter int POS_PARITY   = BIT_PARITY,
  parameter int POS_ADDR_MEM = BIT_ADDR_MEM,
  parameter int POS_ADDR_IO  = BIT_ADDR_IO
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_busy,
  input  logic    cyc_cpu,
  input  logic    cyc_io,
  input  logic    prot_err_n,
  input  logic    par_err_n,
  input  logic    addr_err_n,
  output fr_vec_t set_o
);
  localparam fr_vec_t M_PROT_CPU = bit_at(POS_PROT_CPU);
  localparam fr_vec_t M_PROT_OTH = bit_at(POS_PROT_OTH);
  localparam fr_vec_t M_PARITY   = bit_at(POS_PARITY);
  localparam fr_vec_t M_ADDR_MEM = bit_at(POS_ADDR_MEM);
  localparam fr_vec_t M_ADDR_IO  = bit_at(POS_ADDR_IO);

  logic busy_q, cpu_q, io_q;
  logic prot_q, par_q, addr_q;   // active-high copies of the errors
  logic cycle_end;

  // register every input each clock so the values seen in the last busy cycle are kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cpu_q  <= 1'b0;
      io_q   <= 1'b0;
      prot_q <= 1'b0;
      par_q  <= 1'b0;
      addr_q <= 1'b0;
    end else begin
      busy_q <= bus_busy;
      cpu_q  <= cyc_cpu;
      io_q   <= cyc_io;
      prot_q <= ~prot_err_n;
      par_q  <= ~par_err_n;
      addr_q <= ~addr_err_n;
    end
  end

  assign cycle_end = busy_q & ~bus_busy;

  always_comb begin
    set_o = '0;
    if (cycle_end) begin
      if (prot_q) set_o = set_o | (cpu_q ? M_PROT_CPU : M_PROT_OTH);
      if (par_q)  set_o = set_o | M_PARITY;
      if (addr_q) set_o = set_o | (io_q ? M_ADDR_IO : M_ADDR_MEM);
    end
  end

  // R6: bus errors are taken only when a cycle ends
  p_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && !bus_busy) |-> (set_o == '0));
  // R2/R3: a protection error reaches one target bit, never both
  p_prot_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o[POS_PROT_CPU] && set_o[POS_PROT_OTH]));
  // R5: an address error reaches one target bit, never both
  p_addr_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_o[POS_ADDR_MEM] && set_o[POS_ADDR_IO]));
endmodule

// File: rtl/fr_store.sv
module fr_store
  import fr_pkg::*;
#(
  parameter fr_vec_t VALID_MASK = '1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  fr_vec_t set_i,
  input  logic    clr_i,
  output fr_vec_t q_o
);
  fr_vec_t q_r;

  // a new set is ORed in after the clear, so it wins the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= ((clr_i ? '0 : q_r) | set_i) & VALID_MASK;
  end

  assign q_o = q_r;

  // R10: a bit stays set while no clear arrives
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((q_r & $past(q_r)) == $past(q_r)));
  // R10: a clear with no new set empties the register
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (set_i == '0)) |=> (q_r == '0));
  // R11: a set bit is present after the edge, clear or not
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_r & $past(set_i & VALID_MASK)) == $past(set_i & VALID_MASK)));
  // R12: bits without a source never become 1
  p_unassigned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r & ~VALID_MASK) == '0);
endmodule

// File: rtl/fault_reg_capture.sv
module fault_reg_capture
  import fr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int POS_PROT_CPU = BIT_PROT_CPU,
  parameter int POS_PROT_OTH = BIT_PROT_OTH,
  parameter int POS_PARITY   = BIT_PARITY,
  parameter int POS_ADDR_MEM = BIT_ADDR_MEM,
  parameter int POS_ADDR_IO  = BIT_ADDR_IO,
  parameter int POS_SYS0     = BIT_SYS0,
  parameter int POS_SYS1_LO  = BIT_SYS1_LO,
  parameter int POS_SYS1_HI  = BIT_SYS1_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_busy,
  input  logic              cyc_cpu,
  input  logic              cyc_io,
  input  logic              prot_err_n,
  input  logic              par_err_n,
  input  logic              addr_err_n,
  input  logic [NUM_SYS-1:0] sys_fault,
  input  logic              rd_en,
  input  logic              clr_en,
  output logic [FR_W-1:0]   rd_data
);
  localparam fr_vec_t SYS_MASK [NUM_SYS] = '{
    bit_at(POS_SYS0),
    bit_at(POS_SYS1_LO) | bit_at(POS_SYS1_HI)
  };
  localparam fr_vec_t BUS_MASK = bit_at(POS_PROT_CPU) | bit_at(POS_PROT_OTH) |
                                 bit_at(POS_PARITY) | bit_at(POS_ADDR_MEM) |
                                 bit_at(POS_ADDR_IO);
  localparam fr_vec_t VALID_MASK = BUS_MASK | SYS_MASK[0] | SYS_MASK[1];

  fr_vec_t bus_set;
  fr_vec_t sys_set [NUM_SYS];
  fr_vec_t all_set;
  fr_vec_t reg_q;

  fr_bus_sampler #(
    .POS_PROT_CPU(POS_PROT_CPU),
    .POS_PROT_OTH(POS_PROT_OTH),
    .POS_PARITY  (POS_PARITY),
    .POS_ADDR_MEM(POS_ADDR_MEM),
    .POS_ADDR_IO (POS_ADDR_IO)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_busy  (bus_busy),
    .cyc_cpu   (cyc_cpu),
    .cyc_io    (cyc_io),
    .prot_err_n(prot_err_n),
    .par_err_n (par_err_n),
    .addr_err_n(addr_err_n),
    .set_o     (bus_set)
  );

  for (genvar g = 0; g < NUM_SYS; g++) begin : g_sys
    logic rise;
    fr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(sys_fault[g]),
      .rise_o (rise)
    );
    assign sys_set[g] = rise ? SYS_MASK[g] : '0;
  end

  always_comb begin
    all_set = bus_set;
    for (int i = 0; i < NUM_SYS; i++) all_set = all_set | sys_set[i];
  end

  fr_store #(.VALID_MASK(VALID_MASK)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(all_set),
    .clr_i(clr_en),
    .q_o  (reg_q)
  );

  assign rd_data = rd_en ? reg_q : '0;

  // R13: an idle read port drives zero
  p_read_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
  // R8: the two bits of system fault 1 always move together
  p_sys1_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[POS_SYS1_LO] == reg_q[POS_SYS1_HI]));
endmodule

// File: tb/sim_fault_reg_capture.sv
module sim_fault_reg_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_busy = 1'b0, cyc_cpu = 1'b0, cyc_io = 1'b0;
  logic        prot_err_n = 1'b1, par_err_n = 1'b1, addr_err_n = 1'b1;
  logic [1:0]  sys_fault = 2'b00;
  logic        rd_en = 1'b1, clr_en = 1'b0;
  logic [15:0] rd_data;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  fault_reg_capture u0 (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .cyc_cpu(cyc_cpu),
    .cyc_io(cyc_io), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
    .addr_err_n(addr_err_n), .sys_fault(sys_fault), .rd_en(rd_en),
    .clr_en(clr_en), .rd_data(rd_data)
  );

  // {prot_n, par_n, addr_n, cpu, io, expected}
  localparam logic [20:0] VEC [8] = '{
    {5'b11110, 16'h0000},  // R6: no error, nothing set
    {5'b01110, 16'h0001},  // R2
    {5'b01100, 16'h0002},  // R3
    {5'b10110, 16'h0004},  // R4
    {5'b11010, 16'h0020},  // R5 memory
    {5'b11001, 16'h0100},  // R5 I/O
    {5'b00001, 16'h0106},  // R3 R4 R5
    {5'b00010, 16'h0025}   // R2 R4 R5
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clr_en = 1'b1;
    @(negedge clk) clr_en = 1'b0;
  endtask

  task automatic bus_cycle(input logic p, input logic pa, input logic a,
                           input logic cpu, input logic io);
    @(negedge clk);
    bus_busy = 1'b1; prot_err_n = p; par_err_n = pa; addr_err_n = a;
    cyc_cpu = cpu; cyc_io = io;
    @(negedge clk);
    bus_busy = 1'b0; prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 16'h0000, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 16'h0000, "R1 after reset");

    // table walk
    for (int i = 0; i < 8; i++) begin
      do_clear();
      bus_cycle(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      check(rd_data, VEC[i][15:0], $sformatf("R2 R3 R4 R5 table entry %0d", i));
    end

    // R6: errors low while busy, released before the last busy cycle
    do_clear();
    @(negedge clk) begin bus_busy = 1'b1; prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0; end
    @(negedge clk) begin prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1; end
    @(negedge clk) bus_busy = 1'b0;
    @(negedge clk);
    check(rd_data, 16'h0000, "R6 errors gone before cycle end");
    // R6: errors low with no bus cycle
    @(negedge clk) begin prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0; end
    repeat (4) @(negedge clk);
    prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    check(rd_data, 16'h0000, "R6 errors without bus cycle");

    // R10: sticky, then cleared
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check(rd_data, 16'h0004, "R10 bit held");
    do_clear();
    check(rd_data, 16'h0000, "R10 cleared");

    // R11: set in the same cycle as clear
    bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk) begin bus_busy = 1'b1; prot_err_n = 1'b0; cyc_cpu = 1'b1; end
    @(negedge clk) begin bus_busy = 1'b0; prot_err_n = 1'b1; clr_en = 1'b1; end
    @(negedge clk) clr_en = 1'b0;
    check(rd_data, 16'h0001, "R11 set beats clear");

    // R7: latency of three edges
    do_clear();
    @(negedge clk) sys_fault[0] = 1'b1;
    repeat (2) @(negedge clk);
    check(rd_data, 16'h0000, "R7 not yet after two edges");
    @(negedge clk);
    check(rd_data, 16'h0080, "R7 set after three edges");

    // R9: held level does not set again
    do_clear();
    repeat (4) @(negedge clk);
    check(rd_data, 16'h0000, "R9 held level after clear");

    // R8
    @(negedge clk) sys_fault[1] = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_data, 16'hA000, "R8 both bits");

    // R12: every source active
    do_clear();
    @(negedge clk) sys_fault = 2'b00;
    repeat (4) @(negedge clk);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    bus_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk) sys_fault = 2'b11;
    repeat (3) @(negedge clk);
    check(rd_data, 16'hA1A7, "R12 all sources, unsourced bits zero");

    // R13: read gating
    @(negedge clk) rd_en = 1'b0;
    #1 check(rd_data, 16'h0000, "R13 idle read");
    @(negedge clk) rd_en = 1'b1;
    #1 check(rd_data, 16'hA1A7, "R13 read leaves register intact");

    finish_run();
  end
endmodule